// File: doc/BRIEF.md
# Delay-Line Bring-Up Sequencer

This block is a small hardware sequencer that brings a PHY delay-locked loop out of reset after the card clock has been retuned. A one-cycle pulse marks that the card clock rate has just changed, and a companion input carries the new rate in Hz. If that rate is strictly above a configurable limit, 52 MHz by default, the sequencer starts a fixed three-step bring-up on the 32-bit delay-loop configuration register, which sits at register offset 0x200.

Each step is a read-modify-write completed in one cycle. The block takes the register's current value from `cfg_rdata`, applies the step's masks, and in the same cycle presents the result on a simple write port. After each write it waits `WAIT_CYCLES` clock cycles; the default equals 1 ms at a 100 MHz system clock. The first step switches the loop off and clears its compensation enables. The second step loads the search configuration. The third step turns the loop back on. `busy` is high for the whole run, and `done` pulses for one cycle when the final wait has elapsed.

Top module: `dll_bringup_seq`

## Requirements
- R1: While reset is held and after it is released with no start, `busy`, `done` and `cfg_wr_en` are all 0.
- R2: A run starts only on a cycle where `rate_chg` is 1 and `new_rate_hz` is strictly greater than `RATE_LIMIT_HZ`. A rate equal to or below the limit, or a rate with `rate_chg` at 0, causes no write and leaves `busy` low.
- R3: In the first write the data is the read value with bit 21 and bits 18, 24, 25, 26 and 27 cleared, and every other bit is kept.
- R4: In the second write the data is the read value ORed with 0x0F050C03. This sets compensation bits 18 and 24–27, search bit 16, count field value 0xC00 and phase value 0x3.
- R5: In the third write the data is the read value with bit 21 set.
- R6: Every write uses address 0x200 and lasts exactly one cycle. Consecutive writes are exactly `WAIT_CYCLES`+1 cycles apart, and `cfg_wr_en` is low during the waits.
- R7: `done` is high for exactly one cycle, `WAIT_CYCLES`+1 cycles after the third write. `busy` is already low in that cycle.
- R8: `busy` rises in the cycle after the accepted start, and the first write happens in that same cycle.
- R9: A start pulse that arrives while `busy` is high has no effect. No extra write is made, and the timing of the writes and of `done` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_chg | input | 1 | One-cycle pulse: card clock rate has just changed |
| new_rate_hz | input | RATE_W | New card clock rate in Hz, valid with `rate_chg` |
| cfg_rdata | input | 32 | Current value of the delay-loop configuration register |
| cfg_wr_en | output | 1 | Register write strobe |
| cfg_addr | output | ADDR_W | Register write offset (always 0x200) |
| cfg_wdata | output | 32 | Register write data |
| busy | output | 1 | Bring-up in progress |
| done | output | 1 | One-cycle pulse at the end of bring-up |

## Verification
A wrong state shows up at the write port. A mis-ordered step writes the wrong mask, which can be seen in the very first write. A stuck or miscounted wait timer moves the next write, or the `done` pulse, off its cycle by one or more cycles. A start gate that admits a rate equal to the limit, or that re-arms while busy, shows up as an unexpected write one cycle after the offending pulse. The bench keeps its own model of the register and therefore also catches a mask error in the final register value.

// File: rtl/dll_seq_pkg.sv
// Shared constants and types for the delay-loop bring-up sequencer.
// Assumes a 32-bit configuration register with the bit layout below.
package dll_seq_pkg;
    localparam int REG_W      = 32;
    localparam int EN_BIT     = 21;
    localparam int SEARCH_BIT = 16;

    // compensation enables: bit 18 and bits 24..27
    localparam logic [REG_W-1:0] COMP_MASK =
        (REG_W'(1) << 18) | (REG_W'(4'hF) << 24);
    localparam logic [REG_W-1:0] EN_MASK     = REG_W'(1) << EN_BIT;
    localparam logic [REG_W-1:0] SEARCH_MASK = REG_W'(1) << SEARCH_BIT;
    localparam logic [REG_W-1:0] INIT_COUNT  = REG_W'(32'h0000_0C00);
    localparam logic [REG_W-1:0] PHASE_SEL   = REG_W'(32'h0000_0003);

    // step masks derived from the fields above
    localparam logic [REG_W-1:0] STEP1_CLR = EN_MASK | COMP_MASK;
    localparam logic [REG_W-1:0] STEP2_SET = COMP_MASK | SEARCH_MASK | INIT_COUNT | PHASE_SEL;
    localparam logic [REG_W-1:0] STEP3_SET = EN_MASK;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFF,
        ST_WAIT_OFF,
        ST_CFG,
        ST_WAIT_CFG,
        ST_ON,
        ST_WAIT_ON
    } seq_state_t;
endpackage

// File: rtl/dll_seq_gate.sv
// Start qualifier: accepts a rate-change pulse only when the new rate
// is strictly above the limit. Assumes rate is an unsigned Hz value.
module dll_seq_gate #(
    parameter int          RATE_W        = 32,
    parameter logic [31:0] RATE_LIMIT_HZ = 32'd52_000_000
) (
    input  logic              rate_chg,
    input  logic [RATE_W-1:0] new_rate_hz,
    output logic              start_ok
);
    localparam logic [RATE_W-1:0] LIMIT = RATE_W'(RATE_LIMIT_HZ);

    // qualify the pulse against the threshold
    always_comb begin
        start_ok = rate_chg && (new_rate_hz > LIMIT);
    end
endmodule

// File: rtl/dll_seq_timer.sv
// Settle timer: loads WAIT_CYCLES-1 on load and counts down to zero.
// Assumes WAIT_CYCLES >= 1; zero is high in the last wait cycle.
module dll_seq_timer #(
    parameter int WAIT_CYCLES = 100_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    localparam int CNT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // reload on a step, otherwise count down and hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // flag the final wait cycle
    always_comb begin
        zero = (cnt_q == '0);
    end

    // R6
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == RELOAD));
endmodule

// File: rtl/dll_seq_rmw.sv
// Read-modify-write datapath: applies the mask of the active step to the
// current register value. Assumes the read value is valid in the step cycle.
module dll_seq_rmw
    import dll_seq_pkg::*;
(
    input  seq_state_t       state,
    input  logic [REG_W-1:0] rd_val,
    output logic [REG_W-1:0] wr_val
);
    // select the modification for the current step
    always_comb begin
        case (state)
            ST_OFF:  wr_val = rd_val & ~STEP1_CLR;
            ST_CFG:  wr_val = rd_val | STEP2_SET;
            ST_ON:   wr_val = rd_val | STEP3_SET;
            default: wr_val = rd_val;
        endcase
    end
endmodule

// File: rtl/dll_bringup_seq.sv
// Top of the delay-loop bring-up sequencer. It runs three read-modify-write
// steps (off, configure, on) on the configuration register, each followed by
// a WAIT_CYCLES settle. Assumes cfg_rdata reflects the register combinationally.
module dll_bringup_seq
    import dll_seq_pkg::*;
#(
    parameter int          WAIT_CYCLES   = 100_000,
    parameter int          RATE_W        = 32,
    parameter logic [31:0] RATE_LIMIT_HZ = 32'd52_000_000,
    parameter int          ADDR_W        = 12,
    parameter logic [11:0] CFG_OFFSET    = 12'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_chg,
    input  logic [RATE_W-1:0] new_rate_hz,
    input  logic [31:0]       cfg_rdata,
    output logic              cfg_wr_en,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [31:0]       cfg_wdata,
    output logic              busy,
    output logic              done
);
    seq_state_t state_q, state_d;
    logic start_ok, t_zero, t_load, done_q;

    dll_seq_gate #(.RATE_W(RATE_W), .RATE_LIMIT_HZ(RATE_LIMIT_HZ)) u_gate (
        .rate_chg    (rate_chg),
        .new_rate_hz (new_rate_hz),
        .start_ok    (start_ok)
    );

    dll_seq_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .zero  (t_zero)
    );

    dll_seq_rmw u_rmw (
        .state  (state_q),
        .rd_val (cfg_rdata),
        .wr_val (cfg_wdata)
    );

    // next-state logic of the step sequence
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (start_ok) state_d = ST_OFF;
            ST_OFF:      state_d = ST_WAIT_OFF;
            ST_WAIT_OFF: if (t_zero) state_d = ST_CFG;
            ST_CFG:      state_d = ST_WAIT_CFG;
            ST_WAIT_CFG: if (t_zero) state_d = ST_ON;
            ST_ON:       state_d = ST_WAIT_ON;
            ST_WAIT_ON:  if (t_zero) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and end-of-run pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_WAIT_ON) && t_zero;
        end
    end

    // step cycles write and restart the settle timer
    always_comb begin
        t_load    = (state_q == ST_OFF) || (state_q == ST_CFG) || (state_q == ST_ON);
        cfg_wr_en = t_load;
        cfg_addr  = ADDR_W'(CFG_OFFSET);
        busy      = (state_q != ST_IDLE);
        done      = done_q;
    end

    // R6
    write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> !cfg_wr_en);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_ok));
    // R8
    first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cfg_wr_en);
    // R3
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && state_q == ST_OFF) |-> ((cfg_wdata & STEP1_CLR) == '0));
    // R5
    on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && state_q == ST_ON) |-> cfg_wdata[EN_BIT]);
endmodule

// File: tb/dll_bringup_seq_test.sv
module dll_bringup_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 5;
    localparam int WATCHDOG   = 150_000;
    localparam logic [31:0] LIM = 32'd52_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_chg = 1'b0;
    logic [31:0] new_rate_hz = '0;
    logic [31:0] reg_q;
    logic        cfg_wr_en, busy, done;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic        preload = 1'b0;
    logic [31:0] preload_val = '0;
    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dll_bringup_seq #(.WAIT_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .rate_chg(rate_chg), .new_rate_hz(new_rate_hz),
        .cfg_rdata(reg_q), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .busy(busy), .done(done)
    );

    // bench model of the configuration register
    always @(posedge clk) begin
        if (preload) reg_q <= preload_val;
        else if (cfg_wr_en && cfg_addr == 12'h200) reg_q <= cfg_wdata;
    end

    function automatic logic [31:0] step1(logic [31:0] x); return x & 32'hF0DB_FFFF; endfunction
    function automatic logic [31:0] step2(logic [31:0] x); return x | 32'h0F05_0C03; endfunction
    function automatic logic [31:0] step3(logic [31:0] x); return x | 32'h0020_0000; endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one scenario: preload, pulse, then follow 3W+5 cycles
    task automatic run(logic [31:0] init, logic [31:0] rate, logic pulse, logic go, int mid);
        logic [31:0] m;
        @(negedge clk); preload = 1'b1; preload_val = init;
        @(negedge clk); preload = 1'b0;
        rate_chg = pulse; new_rate_hz = rate;
        m = init;
        for (int n = 1; n <= 3*W + 5; n++) begin
            @(negedge clk);
            rate_chg = 1'b0;
            if (go) begin
                check("R8 busy", busy, (n >= 1 && n <= 3*W + 3));
                check("R6 wr_en", cfg_wr_en, (n == 1 || n == W + 2 || n == 2*W + 3));
                check("R7 done", done, (n == 3*W + 4));
                if (n == 1) begin
                    m = step1(m); check("R3 step1 data", cfg_wdata, m);
                    check("R6 addr", cfg_addr, 12'h200);
                end
                if (n == W + 2) begin m = step2(m); check("R4 step2 data", cfg_wdata, m); end
                if (n == 2*W + 3) begin m = step3(m); check("R5 step3 data", cfg_wdata, m); end
                if (n == mid) begin rate_chg = 1'b1; new_rate_hz = 32'd200_000_000; end // R9
            end else begin
                check("R2 no busy", busy, 1'b0);
                check("R2 no write", cfg_wr_en, 1'b0);
                check("R2 no done", done, 1'b0);
            end
        end
        check(go ? "R9 final reg" : "R2 reg untouched", reg_q, go ? step3(step2(step1(init))) : init);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1
        check("R1 busy in reset", busy, 1'b0);
        check("R1 done in reset", done, 1'b0);
        check("R1 wr in reset", cfg_wr_en, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 busy idle", busy, 1'b0);
        check("R1 wr idle", cfg_wr_en, 1'b0);
        // R2 boundary: exactly the limit, below, and no pulse
        run(32'hFFFF_FFFF, LIM, 1'b1, 1'b0, 0);
        run(32'h1234_5678, 32'd400_000, 1'b1, 1'b0, 0);
        run(32'h1234_5678, 32'd200_000_000, 1'b0, 1'b0, 0);
        // just above the limit, all-ones and all-zeros registers
        run(32'hFFFF_FFFF, LIM + 1, 1'b1, 1'b1, 0);
        run(32'h0000_0000, LIM + 1, 1'b1, 1'b1, 0);
        // R9: restart attempts mid-wait and in the last busy cycle
        run(32'hA5A5_5A5A, 32'd100_000_000, 1'b1, 1'b1, 3);
        run(32'h0F24_0000, 32'd100_000_000, 1'b1, 1'b1, 3*W + 3);
        // random mix
        for (int i = 0; i < 12; i++) begin
            logic [31:0] r, v;
            int md;
            v = $urandom;
            r = LIM - 32'd4 + ($urandom % 9);
            if ($urandom % 2 == 0) r = $urandom % 32'd300_000_000;
            md = ($urandom % 2 == 0) ? 0 : 2 + int'($urandom % (3*W + 2));
            run(v, r, 1'b1, (r > LIM), md);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule